// File: doc/BRIEF.md
# Byte-Wide Static Memory with Asynchronous Strobes

This block is a clocked, synthesizable stand-in for a byte-wide static memory that is controlled by asynchronous strobes. Three active-low strobes arrive from outside: a select, a store strobe and a drive strobe. They arrive together with an address and a bidirectional data bus. A fast system clock oversamples every strobe through a synchronizer. The block then decides whether the memory is in a read or a write cycle, and it owns the tri-state control of the data bus.

A store happens during the window in which the select and the store strobe are both low. The window opens on whichever of the two falls last. It closes on whichever rises first. The byte committed is the bus value seen on the last sampled clock before the window closes.

The bus rules depend on which strobe controls the write. If the select controls it, the bus stays released for the whole cycle. If the store strobe controls it, the bus follows the drive strobe outside the window. A write-protect level from a power supervisor blocks every store and keeps the bus released.

Top module: `sram_strobe_top`

## Requirements
- R1: With the select low, the store strobe high and the drive strobe low, the bus carries the byte stored at the presented address within eight clocks.
- R2: The array has 2^ADDR_W independent byte locations (ADDR_W = 17 gives 131,072 bytes), including address 0 and the all-ones address.
- R3: A store takes place only when the select and the store strobe are low at the same time, whichever of the two fell last.
- R4: The stored byte is the bus value on the last sample before the earlier of the two rising strobes. Bus changes inside the window before that sample are superseded, and bus changes after the window has closed are not stored.
- R5: After a window closes, no new store can start until the store strobe has been seen high. Pulsing the select again while the store strobe stays low stores nothing.
- R6: In a write controlled by the select, the bus is released during the window even when the drive strobe is low.
- R7: In a write controlled by the store strobe, the bus is released inside the window. While the select is low outside the window, the bus is driven with the stored byte if the drive strobe is low and released if it is high.
- R8: The block drives the bus only when the select and the drive strobe are low and the store strobe is high. Otherwise the bus is released.
- R9: While write-protect is high, no store changes the array and the bus stays released.
- R10: During reset and right after it, the bus is released, whatever the strobe levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Select strobe, active low, asynchronous |
| writeEnN | input | 1 | Store strobe, active low, asynchronous |
| outEnN | input | 1 | Drive strobe, active low, asynchronous |
| wrProtect | input | 1 | Write-protect level from the supervisor, high blocks stores |
| addr | input | ADDR_W | Byte address |
| dataIo | inout | DATA_W | Bidirectional data bus |

## Verification
The bench builds the block with ADDR_W = 8, DATA_W = 8 and SYNC_STAGES = 2. With a 256-byte array, both end addresses are easy to reach, and the bench can keep a shadow model of every location. Two synchronizer stages keep strobe phases short, so the bench can try both controlling strobes and both drive-strobe levels. It can also move the bus inside and after a window, re-pulse the select with the store strobe held low, and run with write-protect raised. A pull-up on the bench side of the bus makes a released bus read as all ones, and no stored test byte uses that value.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic wrCommit;  // store the captured byte this cycle
    logic busDrive;  // put the read register on the bus
  } sramCtl_t;

endpackage

// File: rtl/sram_strobe_ctl.sv
module sram_strobe_ctl
  import sram_strobe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     chipEnN,
  input  logic     writeEnN,
  input  logic     outEnN,
  input  logic     wrProtect,
  output sramCtl_t ctl
);

  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] IDLE_LVL = '1;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] syncStage [SYNC_STAGES];
  logic [NSIG-1:0] synced;

  assign rawIn = {wrProtect, outEnN, writeEnN, chipEnN};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[g] <= IDLE_LVL;
          else       syncStage[g] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[g] <= IDLE_LVL;
          else       syncStage[g] <= syncStage[g-1];
        end
      end
    end
  endgenerate

  assign synced = syncStage[SYNC_STAGES-1];

  logic ceS, weS, oeS, wpS;
  assign ceS = synced[0];
  assign weS = synced[1];
  assign oeS = synced[2];
  assign wpS = synced[3];

  logic winNow, winPrev, winEnd, weArmed;

  // A window opens only while the store strobe is armed
  assign winNow = ~ceS & ~weS & weArmed;
  assign winEnd = winPrev & ~winNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winPrev <= 1'b0;
      weArmed <= 1'b0;
    end else begin
      winPrev <= winNow;
      weArmed <= weS | (weArmed & ~winEnd);
    end
  end

  assign ctl.wrCommit = winEnd & ~wpS;
  assign ctl.busDrive = ~ceS & weS & ~oeS & ~wpS;

  p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrCommit |=> !ctl.wrCommit);

  p_commit_after_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrCommit |-> $past(!ceS && !weS));

  p_we_rearm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!weArmed && !weS) |=> !winNow);

  p_protect_no_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wpS) && wpS) |-> !ctl.wrCommit);

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  sramCtl_t          ctl,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrPipe [SYNC_STAGES];
  logic [DATA_W-1:0] dataPipe [SYNC_STAGES];
  logic [ADDR_W-1:0] addrPrev;
  logic [DATA_W-1:0] dataPrev;

  // Delay address and data by the strobe synchronizer depth so that they line up
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_align
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) begin
            addrPipe[g] <= '0;
            dataPipe[g] <= '0;
          end else begin
            addrPipe[g] <= addr;
            dataPipe[g] <= dataIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) begin
            addrPipe[g] <= '0;
            dataPipe[g] <= '0;
          end else begin
            addrPipe[g] <= addrPipe[g-1];
            dataPipe[g] <= dataPipe[g-1];
          end
        end
      end
    end
  endgenerate

  // One more stage: the sample taken just before the closing edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPrev <= '0;
      dataPrev <= '0;
      rdData   <= '0;
    end else begin
      addrPrev <= addrPipe[SYNC_STAGES-1];
      dataPrev <= dataPipe[SYNC_STAGES-1];
      rdData   <= mem[addrPipe[SYNC_STAGES-1]];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrCommit) mem[addrPrev] <= dataPrev;
  end

  p_mem_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrCommit |=> mem[$past(addrPrev)] == $past(dataPrev));

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrCommit |=> mem[$past(addrPrev)] == $past(mem[addrPrev]));

endmodule

// File: rtl/sram_strobe_top.sv
module sram_strobe_top
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              writeEnN,
  input  logic              outEnN,
  input  logic              wrProtect,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataIo
);

  sramCtl_t          ctl;
  logic [DATA_W-1:0] rdData;

  sram_strobe_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .chipEnN  (chipEnN),
    .writeEnN (writeEnN),
    .outEnN   (outEnN),
    .wrProtect(wrProtect),
    .ctl      (ctl)
  );

  sram_strobe_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .dataIn(dataIo),
    .ctl   (ctl),
    .rdData(rdData)
  );

  assign dataIo = ctl.busDrive ? rdData : {DATA_W{1'bz}};

endmodule

// File: tb/tb_sram_strobe_top.sv
module tb_sram_strobe_top;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [DW-1:0] PULL = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, wp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] tbData = '0;
  logic tbDrv = 1'b0;
  wire  [DW-1:0] dataIo;

  always #10 clk = ~clk;  // 50 MHz

  assign dataIo = tbDrv ? tbData : {DW{1'bz}};
  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (dataIo[i]);
  end

  sram_strobe_top #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .chipEnN(ceN), .writeEnN(weN), .outEnN(oeN),
    .wrProtect(wp), .addr(addr), .dataIo(dataIo)
  );

  typedef struct {
    logic [DW-1:0] exp;
    bit            hiz;
    string         tag;
  } item_t;

  item_t q[$];
  logic [DW-1:0] model [1<<AW];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Monitor: compares each expected item against the bus
  initial begin
    forever begin
      wait (q.size() != 0);
      #1;
      begin
        item_t it;
        logic [DW-1:0] want;
        it = q.pop_front();
        want = it.hiz ? PULL : it.exp;
        checks++;
        if (dataIo !== want) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, dataIo, want);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectBus(logic [DW-1:0] v, bit hiz, string tag);
    item_t it;
    it.exp = v; it.hiz = hiz; it.tag = tag;
    q.push_back(it);
    #3;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
    addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    step(6);
    expectBus(e, 1'b0, tag);
    ceN = 1'b1; oeN = 1'b1;
    step(4);
  endtask

  // Write ended and controlled by the select strobe
  task automatic wrCe(logic [AW-1:0] a, logic [DW-1:0] d, logic oe);
    addr = a; oeN = oe; weN = 1'b0;
    step(3);
    ceN = 1'b0;
    step(4);
    if (!oe) expectBus('0, 1'b1, "R6 window released with drive strobe low");
    tbData = d; tbDrv = 1'b1;
    step(3);
    ceN = 1'b1;
    step(1);
    tbDrv = 1'b0;
    step(2);
    weN = 1'b1; oeN = 1'b1;
    step(3);
    if (!wp) model[a] = d;
  endtask

  // Write controlled by the store strobe, select held low around it
  task automatic wrWe(logic [AW-1:0] a, logic [DW-1:0] d, logic oe);
    addr = a; oeN = oe; weN = 1'b1; ceN = 1'b0;
    step(5);
    expectBus(model[a], oe, oe ? "R8 drive strobe high before window" : "R7 driven before window");
    weN = 1'b0;
    step(4);
    expectBus('0, 1'b1, "R7 window released");
    tbData = d; tbDrv = 1'b1;
    step(3);
    weN = 1'b1;
    step(1);
    tbDrv = 1'b0;
    model[a] = d;
    step(5);
    expectBus(d, oe, oe ? "R8 drive strobe high after window" : "R7 driven after window");
    ceN = 1'b1; oeN = 1'b1;
    step(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: read strobes asserted during reset, bus must stay released
    ceN = 1'b0; oeN = 1'b0;
    step(5);
    expectBus('0, 1'b1, "R10 released during reset");
    rstN = 1'b1;
    step(1);
    expectBus('0, 1'b1, "R10 released right after reset");
    ceN = 1'b1; oeN = 1'b1;
    step(4);

    // R2 / R6: both end addresses, select-controlled
    wrCe(8'h00, 8'h11, 1'b0);
    wrCe(8'hFF, 8'hA5, 1'b1);
    rd(8'h00, 8'h11, "R2 address zero");
    rd(8'hFF, 8'hA5, "R2 all-ones address");

    // R7 / R8 / R3: store-controlled writes
    wrWe(8'h00, 8'h5A, 1'b0);
    wrWe(8'hFF, 8'h3C, 1'b1);
    rd(8'hFF, 8'h3C, "R3 store-controlled write");

    // R4: bus change after the window closes is ignored
    addr = 8'h10; oeN = 1'b1; ceN = 1'b0;
    step(3);
    weN = 1'b0; tbData = 8'h66; tbDrv = 1'b1;
    step(4);
    weN = 1'b1;
    step(1);
    tbData = 8'h99;
    step(4);
    ceN = 1'b1; tbDrv = 1'b0;
    step(4);
    model[8'h10] = 8'h66;
    rd(8'h10, 8'h66, "R4 late bus change ignored");

    // R4: last in-window value wins
    addr = 8'h11; ceN = 1'b0;
    step(3);
    weN = 1'b0; tbData = 8'h21; tbDrv = 1'b1;
    step(3);
    tbData = 8'h42;
    step(3);
    weN = 1'b1;
    step(1);
    tbDrv = 1'b0;
    step(2);
    ceN = 1'b1;
    step(4);
    model[8'h11] = 8'h42;
    rd(8'h11, 8'h42, "R4 last in-window value stored");

    // R5: second select pulse with store strobe held low stores nothing
    addr = 8'h20; weN = 1'b0; tbData = 8'h71; tbDrv = 1'b1;
    step(3);
    ceN = 1'b0;
    step(4);
    ceN = 1'b1;
    step(4);
    tbData = 8'h17;
    ceN = 1'b0;
    step(4);
    ceN = 1'b1;
    step(2);
    tbDrv = 1'b0; weN = 1'b1;
    step(4);
    model[8'h20] = 8'h71;
    rd(8'h20, 8'h71, "R5 no store without store strobe re-arm");

    // R8: no drive without select, or with drive strobe high
    addr = 8'h20; ceN = 1'b1; oeN = 1'b0; weN = 1'b1;
    step(6);
    expectBus('0, 1'b1, "R8 select high");
    ceN = 1'b0; oeN = 1'b1;
    step(6);
    expectBus('0, 1'b1, "R8 drive strobe high");
    ceN = 1'b1;
    step(4);

    // R9: write-protect blocks stores and drive
    wp = 1'b1;
    step(4);
    wrCe(8'h00, 8'h77, 1'b1);
    addr = 8'h00; ceN = 1'b0; oeN = 1'b0;
    step(6);
    expectBus('0, 1'b1, "R9 bus released under protect");
    ceN = 1'b1; oeN = 1'b1;
    wp = 1'b0;
    step(4);
    rd(8'h00, 8'h5A, "R9 protected store ignored");

    // R1: several patterns read back in a different order
    for (int k = 0; k < 4; k++) wrCe(8'h40 + 8'(k * 17), 8'h80 + 8'(k * 9), 1'b1);
    for (int k = 3; k >= 0; k--) rd(8'h40 + 8'(k * 17), model[8'h40 + 8'(k * 17)], "R1 read pattern");

    step(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule